// File: doc/BRIEF.md
# Pulse-Width Coax Status Transmitter

This block answers a poll from the cluster controller. It sends a 13-bit status word onto the coax line using a pulse-width code. A one is sent as a long active pulse and a zero as a short one. Each bit occupies the same fixed period. The period comes from a free-running width counter, which the receiver side holds at zero while an incoming word is on the line.

On a start strobe, the block records a pending request. At the next bit-period boundary it captures the status inputs: busy, device check, transmit check, info pending and a 5-bit attention code. It then frames the word, computes odd parity, and shifts the word out with the output enable asserted. When the thirteenth bit ends, the block pulses a done flag and releases the line.

Top module: `coax_status_tx`

## Requirements
- R1: While rst_ni is low, tx_o, tx_oe_o and done_o are all low.
- R2: Each bit period lasts exactly BIT_CYCLES (15) clock cycles. Bit periods follow one another with no gap, so a word occupies 13 x 15 = 195 cycles.
- R3: Every bit's active pulse starts at the first cycle of its period.
  - A one-bit holds tx_o high for ONE_CYCLES (11) cycles and then low for the rest of the period.
  - A zero-bit holds tx_o high for ZERO_CYCLES (3) cycles and then low.
- R4: Bits are sent in order from bit 1 to bit 13:
  - bit 1 = 1, bit 2 = 0;
  - bit 3 = busy_i, bit 4 = dev_chk_i, bit 5 = xmit_chk_i, bit 6 = info_pend_i;
  - bits 7 to 11 = attn_i[4] down to attn_i[0];
  - bit 13 = 1.
- R5: Bit 12 is chosen so that bits 1 to 12 hold an odd number of ones.
- R6: The status inputs are captured at the boundary where the word begins. Changes to them after tx_oe_o rises do not alter the word in flight.
- R7: After a one-cycle start_i pulse, tx_oe_o rises within 16 cycles, on the next boundary of the free-running counter.
- R8: While rx_active_i is high, the width counter is held at zero and no word begins. After rx_active_i falls, a pending word begins exactly 15 cycles later.
- R9: tx_oe_o is high for exactly the 13 bit periods of a word. tx_o is never high while tx_oe_o is low.
- R10: In the cycle after the thirteenth bit period ends, done_o is high for exactly one cycle and tx_oe_o is low.
- R11: The pending request is cleared at the boundary where bit 12 begins. This determines what happens to a start_i pulse that arrives during a word:
  - During bits 1 to 11, it is absorbed and produces no further word.
  - During bits 12 or 13, it produces a second word. That word begins one full idle bit period after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-timing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_active_i | input | 1 | Incoming word on the line; holds the width counter and defers sending |
| start_i | input | 1 | Poll reply request strobe |
| busy_i | input | 1 | Busy status |
| dev_chk_i | input | 1 | Device check status |
| xmit_chk_i | input | 1 | Transmit check status |
| info_pend_i | input | 1 | Info pending status |
| attn_i | input | 5 | Attention code |
| tx_o | output | 1 | Serial line drive, high = active pulse |
| tx_oe_o | output | 1 | Line driver enable |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
A stuck or misaligned width counter shows up within the first bit period of a word. It appears as a pulse of the wrong length or a late rising edge of tx_oe_o. A wrong shift index or parity latch corrupts a single bit's pulse width, and the per-cycle comparison pins it to the exact bit and cycle. A request latch that clears at the wrong boundary is exposed by a start pulse inside a word. It shows as an extra word, or a missing one, within two bit periods of done_o.

// File: rtl/coax_tx_pkg.sv
package coax_tx_pkg;
  localparam int WORD_BITS = 13;
  localparam int ATTN_W    = 5;

  typedef struct packed {
    logic              busy;
    logic              dev_chk;
    logic              xmit_chk;
    logic              info_pend;
    logic [ATTN_W-1:0] attn;
  } status_t;
endpackage

// File: rtl/coax_bit_timer.sv
module coax_bit_timer #(
  parameter int BIT_CYCLES  = 15,
  parameter int ZERO_CYCLES = 3,
  parameter int ONE_CYCLES  = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic wrap_o,
  output logic zero_stb_o,
  output logic one_stb_o
);
  localparam int CW = $clog2(BIT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i || cnt_q == LAST)  cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o     = (cnt_q == LAST) && !clear_i;
  assign zero_stb_o = cnt_q < CW'(ZERO_CYCLES);
  assign one_stb_o  = cnt_q < CW'(ONE_CYCLES);

  AST_STROBE_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_stb_o |-> one_stb_o); // R3
  AST_CNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> zero_stb_o); // R8
endmodule

// File: rtl/coax_status_framer.sv
module coax_status_framer
  import coax_tx_pkg::*;
(
  input  status_t               stat_i,
  output logic [WORD_BITS-1:0]  frame_o,
  output logic                  par_o
);
  // frame_o[WORD_BITS-1] is bit 1, sent first; parity slot left zero
  assign frame_o = {1'b1, 1'b0, stat_i, 1'b0, 1'b1};
  // odd total over bits 1..12
  assign par_o   = ~^frame_o[WORD_BITS-1:2];
endmodule

// File: rtl/coax_word_shifter.sv
module coax_word_shifter
  import coax_tx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wrap_i,
  input  logic                 req_i,
  input  logic [WORD_BITS-1:0] frame_i,
  input  logic                 par_i,
  output logic                 bit_o,
  output logic                 active_o,
  output logic                 par_slot_o,
  output logic                 done_o
);
  localparam int IW = $clog2(WORD_BITS);
  localparam logic [IW-1:0] PAR_IDX  = IW'(WORD_BITS - 2);
  localparam logic [IW-1:0] LAST_IDX = IW'(WORD_BITS - 1);

  logic [WORD_BITS-1:0] sreg_q;
  logic [IW-1:0]        idx_q;
  logic                 par_q, active_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q   <= '0;
      idx_q    <= '0;
      par_q    <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wrap_i) begin
        if (!active_q) begin
          if (req_i) begin
            sreg_q   <= frame_i;
            par_q    <= par_i;
            idx_q    <= '0;
            active_q <= 1'b1;
          end
        end else if (idx_q == LAST_IDX) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          sreg_q <= {sreg_q[WORD_BITS-2:0], 1'b0};
          idx_q  <= idx_q + 1'b1;
        end
      end
    end
  end

  assign bit_o      = (idx_q == PAR_IDX) ? par_q : sreg_q[WORD_BITS-1];
  assign active_o   = active_q;
  assign done_o     = done_q;
  // boundary into the parity bit: request consumed here
  assign par_slot_o = wrap_i && active_q && (idx_q == PAR_IDX - 1'b1);

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (idx_q <= LAST_IDX)); // R2
endmodule

// File: rtl/coax_status_tx.sv
module coax_status_tx
  import coax_tx_pkg::*;
#(
  parameter int BIT_CYCLES  = 15,
  parameter int ZERO_CYCLES = 3,
  parameter int ONE_CYCLES  = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_active_i,
  input  logic       start_i,
  input  logic       busy_i,
  input  logic       dev_chk_i,
  input  logic       xmit_chk_i,
  input  logic       info_pend_i,
  input  logic [4:0] attn_i,
  output logic       tx_o,
  output logic       tx_oe_o,
  output logic       done_o
);
  logic                 wrap, zero_stb, one_stb;
  logic                 req_q, cur_bit, active, par_slot, par;
  logic [WORD_BITS-1:0] frame;
  status_t              stat;

  assign stat = '{busy: busy_i, dev_chk: dev_chk_i, xmit_chk: xmit_chk_i,
                  info_pend: info_pend_i, attn: attn_i};

  coax_bit_timer #(
    .BIT_CYCLES (BIT_CYCLES),
    .ZERO_CYCLES(ZERO_CYCLES),
    .ONE_CYCLES (ONE_CYCLES)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (rx_active_i),
    .wrap_o    (wrap),
    .zero_stb_o(zero_stb),
    .one_stb_o (one_stb)
  );

  coax_status_framer u_framer (
    .stat_i (stat),
    .frame_o(frame),
    .par_o  (par)
  );

  coax_word_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (wrap),
    .req_i     (req_q),
    .frame_i   (frame),
    .par_i     (par),
    .bit_o     (cur_bit),
    .active_o  (active),
    .par_slot_o(par_slot),
    .done_o    (done_o)
  );

  // a new strobe wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       req_q <= 1'b0;
    else if (start_i)  req_q <= 1'b1;
    else if (par_slot) req_q <= 1'b0;
  end

  assign tx_oe_o = active;
  assign tx_o    = active && (zero_stb || (cur_bit && one_stb));

  AST_LINE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_oe_o |-> !tx_o); // R9
  AST_DONE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_oe_o); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_FIRST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_oe_o) |-> tx_o); // R4
endmodule

// File: tb/coax_status_tx_test.sv
`timescale 1ns/1ps
module coax_status_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_active = 1'b0;
  logic       start = 1'b0;
  logic [8:0] stat = '0;
  logic       tx, tx_oe, done;
  int         n_checks = 0, n_fail = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;

  coax_status_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_active_i(rx_active), .start_i(start),
    .busy_i(stat[8]), .dev_chk_i(stat[7]), .xmit_chk_i(stat[6]),
    .info_pend_i(stat[5]), .attn_i(stat[4:0]),
    .tx_o(tx), .tx_oe_o(tx_oe), .done_o(done)
  );

  // {busy,dev,xmit,info,attn[4:0]} , expected parity bit
  localparam logic [9:0] VEC [6] = '{
    {9'h000, 1'b0}, {9'h1FF, 1'b1}, {9'h100, 1'b1},
    {9'h0AA, 1'b0}, {9'h015, 1'b1}, {9'h0C3, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] word_of(input logic [8:0] s, input logic p);
    return {1'b1, 1'b0, s, p, 1'b1};
  endfunction

  task automatic launch(input string tag);
    int lat = 0;
    bit quiet = 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat = 1;
    while (!tx_oe && lat < 40) begin
      if (tx) quiet = 0;
      @(negedge clk);
      lat++;
    end
    check(tx_oe && lat <= 16 && quiet, {"R7 start latency ", tag}, lat, 16);
  endtask

  // entered on the negedge where tx_oe was first seen high
  task automatic capture_word(input logic [12:0] w, input int stim_bit,
                              input logic [8:0] late_stat, input string tag);
    for (int b = 0; b < 13; b++) begin
      bit bad = 0;
      int hi = 0;
      int want = w[12-b] ? 11 : 3;
      for (int c = 0; c < 15; c++) begin
        if (!(b == 0 && c == 0)) @(negedge clk);
        if (b == 0 && c == 1) stat = late_stat;  // R6: inputs move mid-word
        if (tx !== (c < want) || tx_oe !== 1'b1) bad = 1;
        if (tx) hi++;
        start = (stim_bit == b + 1 && c == 0);
      end
      if (b == 11) check(!bad, {"R5 R3 parity bit ", tag}, hi, want);
      else         check(!bad, {"R4 R3 R2 R6 bit ", tag}, hi, want);
    end
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1 && tx_oe === 1'b0, {"R10 R9 end ", tag}, {done, tx_oe}, 2);
    @(negedge clk);
    check(done === 1'b0, {"R10 done width ", tag}, done, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int k;
    logic [8:0] s2;
    repeat (3) @(negedge clk);
    check(tx === 0 && tx_oe === 0 && done === 0, "R1 reset outputs", {tx, tx_oe, done}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (7) @(negedge clk);

    foreach (VEC[i]) begin
      stat = VEC[i][9:1];
      launch($sformatf("vec%0d", i));
      capture_word(word_of(VEC[i][9:1], VEC[i][0]), 0, ~VEC[i][9:1],
                   $sformatf("vec%0d", i));
      repeat (i * 3) @(negedge clk);
    end

    // R11 absorbed: strobe during bit 5
    stat = 9'h0AA;
    launch("r11_absorb");
    capture_word(word_of(9'h0AA, 1'b0), 5, 9'h0AA, "r11_absorb");
    k = 0;
    repeat (40) begin @(negedge clk); if (tx_oe || tx) k++; end
    check(k == 0, "R11 strobe in bit 5 absorbed", k, 0);

    // R11 re-arm: strobe during bit 13
    stat = 9'h015;
    launch("r11_rearm");
    s2 = 9'h1C0;
    capture_word(word_of(9'h015, 1'b1), 13, s2, "r11_rearm");
    k = 1;
    while (!tx_oe && k < 40) begin @(negedge clk); k++; end
    check(k == 15, "R11 second word one bit period after done", k, 15);
    capture_word(word_of(s2, ^s2), 0, s2, "r11_second");

    // R8: receive activity defers and realigns
    repeat (5) @(negedge clk);
    rx_active = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    k = 0;
    repeat (40) begin @(negedge clk); if (tx_oe || tx) k++; end
    check(k == 0, "R8 no send while receiving", k, 0);
    stat = 9'h0C3;
    rx_active = 1'b0;
    k = 0;
    while (!tx_oe && k < 40) begin @(negedge clk); k++; end
    check(k == 15, "R8 send after receive ends", k, 15);
    capture_word(word_of(9'h0C3, 1'b0), 0, 9'h0C3, "r8_word");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule